// File: doc/BRIEF.md
# Iterative AES Round-Key Generator and Store

This block turns an AES cipher key into its full list of round keys and keeps all of them for random-access reads by a cipher datapath. One 128-bit round key is produced per clock cycle. The block has no substitution table of its own. It sends one 32-bit word per cycle to an external byte-substitution unit and takes the substituted word back combinationally in the same cycle.

Two key sizes are supported, chosen by a one-bit select. In the narrow mode a 128-bit key produces 11 round keys. In the wide mode a 256-bit key produces 15. A pulse on the start input begins an expansion, and the ready flag stays low until the last round key has been written. After that, a 4-bit index chooses which stored round key appears on the output, with no clock delay.

Top module: `round_key_bank`

## Requirements
- R1: After the asynchronous active-low reset, `keyReady` is 1 and every stored round key reads as all zeros.
- R2: A start sampled while idle drops `keyReady` on the next clock edge. `keyReady` then stays low for exactly 11 clock edges in narrow mode and 15 in wide mode, and rises on the edge that writes the last round key.
- R3: In narrow mode (`wideKey` = 0) the key is taken from `keyIn[255:128]`. The bits `keyIn[127:0]` have no effect on any stored round key.
- R4: Round key 0 equals `keyIn[255:128]`. In wide mode, round key 1 equals `keyIn[127:0]` unchanged.
- R5: Narrow mode stores round keys 0 to 10 following the standard AES-128 expansion. For example, an all-zero key gives round key 1 = 62636363 repeated four times, and key 2b7e151628aed2a6abf7158809cf4f3c gives round key 1 = a0fafe1788542cb123a339392a6c7605.
- R6: Wide mode (`wideKey` = 1) stores round keys 0 to 14 following the standard AES-256 expansion. Even-numbered steps rotate, substitute and add the round constant. Odd-numbered steps only substitute.
- R7: `roundKey` shows the stored key selected by `keyIdx` in the same cycle that `keyIdx` changes, with no register in the read path.
- R8: A `keyIdx` of 15 reads as all zeros.
- R9: A start seen while an expansion is running is ignored. This covers start held high for two cycles and a fresh pulse in the middle of a run: the results and the ready timing do not change.
- R10: The word sent to the substitution unit is the last 32-bit word of the newest round key. On rotating steps it is first rotated left by one byte. The returned word is used in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyIn | input | 256 | Cipher key; bits 255:128 form the first half |
| wideKey | input | 1 | 0 = 128-bit key, 1 = 256-bit key; sampled with start |
| start | input | 1 | Begins an expansion when the block is idle |
| keyIdx | input | 4 | Selects the stored round key to read |
| roundKey | output | 128 | Selected round key |
| keyReady | output | 1 | High when idle and the schedule is complete |
| subOut | output | 32 | Word sent to the external substitution unit |
| subIn | input | 32 | Substituted word returned combinationally |

## Verification
Every generated round key is built from the one before it. A wrong previous-key register, round constant or step parity therefore corrupts the first affected round key and every later one. The error shows on `roundKey` as soon as that index is read after ready rises. A wrong step counter or FSM state shows up as a change in the number of cycles with ready low, which is visible right after the start pulse. The bench reads every index against an independently computed schedule and counts the ready-low cycles. It also checks the two literal round-1 values, index 15, and start pulses arriving while a run is busy.

// File: rtl/rkb_pkg.sv
package rkb_pkg;
  localparam int KEY_W    = 256;
  localparam int BLK_W    = 128;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 4;
  localparam int SLOTS    = 15;
  localparam int LAST_NAR = 10;
  localparam int LAST_WID = 14;

  // Strobes from control to datapath, one action per cycle.
  typedef struct packed {
    logic             loadHi;
    logic             loadLo;
    logic             gen;
    logic             rotStep;
    logic             wide;
    logic [IDX_W-1:0] slot;
    logic [7:0]       rcon;
  } rkb_ctl_t;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic logic [7:0] gfDouble(input logic [7:0] v);
    gfDouble = {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/rkb_ctrl.sv
module rkb_ctrl
  import rkb_pkg::*;
#(
  parameter int IDX_BITS  = IDX_W,
  parameter int LAST_N    = LAST_NAR,
  parameter int LAST_W    = LAST_WID
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     wideKey,
  output rkb_ctl_t ctl,
  output logic     ready
);
  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t                 state;
  logic [IDX_BITS-1:0] stepCtr;
  logic [7:0]          rconReg;
  logic                wideReg;
  logic [IDX_BITS-1:0] lastStep;
  logic                atLast;
  logic                running;

  assign running  = (state == ST_RUN);
  assign lastStep = wideReg ? IDX_BITS'(LAST_W) : IDX_BITS'(LAST_N);
  assign atLast   = (stepCtr == lastStep);

  always_comb begin
    ctl.loadHi  = running && (stepCtr == '0);
    ctl.loadLo  = running && wideReg && (stepCtr == IDX_BITS'(1));
    ctl.gen     = running && !ctl.loadHi && !ctl.loadLo;
    ctl.rotStep = ctl.gen && (!wideReg || !stepCtr[0]);
    ctl.wide    = wideReg;
    ctl.slot    = stepCtr;
    ctl.rcon    = rconReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ready   <= 1'b1;
      stepCtr <= '0;
      rconReg <= 8'h00;
      wideReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            ready   <= 1'b0;
            stepCtr <= '0;
            rconReg <= 8'h01;
            wideReg <= wideKey;
          end
        end
        default: begin
          if (ctl.rotStep) rconReg <= gfDouble(rconReg);
          if (atLast) begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end else begin
            stepCtr <= stepCtr + 1'b1;
          end
        end
      endcase
    end
  end

  // R2: an accepted start takes the flag down on the next edge
  a_r2_start_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> !ready);

  // R9: a busy run keeps stepping regardless of start
  a_r9_busy_keeps_stepping: assert property (@(posedge clk) disable iff (!rstN)
    (running && !atLast) |=> (running && stepCtr == $past(stepCtr) + 1'b1));

  // R6: round constant is live throughout a run
  a_r6_rcon_live: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (rconReg != 8'h00));

  // R2: the step counter never passes the final slot
  a_r2_step_bounded: assert property (@(posedge clk) disable iff (!rstN)
    stepCtr <= IDX_BITS'(LAST_W));
endmodule

// File: rtl/rkb_datapath.sv
module rkb_datapath
  import rkb_pkg::*;
#(
  parameter int KEY_BITS  = KEY_W,
  parameter int BLK_BITS  = BLK_W,
  parameter int WORD_BITS = WORD_W,
  parameter int IDX_BITS  = IDX_W,
  parameter int NSLOT     = SLOTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rkb_ctl_t             ctl,
  input  logic [KEY_BITS-1:0]  keyIn,
  input  logic [IDX_BITS-1:0]  keyIdx,
  input  logic [WORD_BITS-1:0] subIn,
  output logic [WORD_BITS-1:0] subOut,
  output logic [BLK_BITS-1:0]  roundKey
);
  localparam int NWORDS = BLK_BITS / WORD_BITS;
  localparam int BYTE   = 8;

  logic [BLK_BITS-1:0]  prevOld;
  logic [BLK_BITS-1:0]  prevNew;
  logic [BLK_BITS-1:0]  bank [NSLOT];
  logic [WORD_BITS-1:0] lastWord;
  logic [WORD_BITS-1:0] tWord;
  logic [BLK_BITS-1:0]  baseKey;
  logic [BLK_BITS-1:0]  genKey;
  logic [BLK_BITS-1:0]  nextKey;
  logic                 doWrite;

  assign lastWord = prevNew[WORD_BITS-1:0];
  assign subOut   = ctl.rotStep ? {lastWord[WORD_BITS-BYTE-1:0], lastWord[WORD_BITS-1 -: BYTE]}
                                : lastWord;
  assign tWord    = subIn ^ (ctl.rotStep ? {ctl.rcon, {(WORD_BITS-BYTE){1'b0}}} : '0);
  assign baseKey  = ctl.wide ? prevOld : prevNew;

  // Word chain: each word XORs the base word with its left neighbour.
  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    localparam int HI = BLK_BITS - 1 - j * WORD_BITS;
    if (j == 0) begin : g_first
      assign genKey[HI -: WORD_BITS] = baseKey[HI -: WORD_BITS] ^ tWord;
    end else begin : g_rest
      assign genKey[HI -: WORD_BITS] = baseKey[HI -: WORD_BITS] ^ genKey[HI + WORD_BITS -: WORD_BITS];
    end
  end

  always_comb begin
    if (ctl.loadHi)      nextKey = keyIn[KEY_BITS-1 -: BLK_BITS];
    else if (ctl.loadLo) nextKey = keyIn[BLK_BITS-1:0];
    else                 nextKey = genKey;
  end

  assign doWrite = ctl.loadHi || ctl.loadLo || ctl.gen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOld <= '0;
      prevNew <= '0;
      for (int s = 0; s < NSLOT; s++) bank[s] <= '0;
    end else if (doWrite) begin
      prevOld         <= prevNew;
      prevNew         <= nextKey;
      bank[ctl.slot]  <= nextKey;
    end
  end

  always_comb begin
    roundKey = '0;
    for (int s = 0; s < NSLOT; s++)
      if (int'(keyIdx) == s) roundKey = bank[s];
  end

  // R4: the low-half load only happens for a wide key
  a_r4_lo_needs_wide: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLo |-> ctl.wide);

  // R6: at most one write action per cycle
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadHi, ctl.loadLo, ctl.gen}));

  // R10: rotation requests only come with a generate step
  a_r10_rot_in_gen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rotStep |-> ctl.gen);

  // R3: the first load captures the upper key half
  a_r3_hi_captured: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHi |=> (prevNew == $past(keyIn[KEY_BITS-1 -: BLK_BITS])));
endmodule

// File: rtl/round_key_bank.sv
module round_key_bank
  import rkb_pkg::*;
#(
  parameter int KEY_BITS  = KEY_W,
  parameter int BLK_BITS  = BLK_W,
  parameter int WORD_BITS = WORD_W,
  parameter int IDX_BITS  = IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_BITS-1:0]  keyIn,
  input  logic                 wideKey,
  input  logic                 start,
  input  logic [IDX_BITS-1:0]  keyIdx,
  output logic [BLK_BITS-1:0]  roundKey,
  output logic                 keyReady,
  output logic [WORD_BITS-1:0] subOut,
  input  logic [WORD_BITS-1:0] subIn
);
  rkb_ctl_t ctl;

  rkb_ctrl #(
    .IDX_BITS (IDX_BITS),
    .LAST_N   (LAST_NAR),
    .LAST_W   (LAST_WID)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wideKey (wideKey),
    .ctl     (ctl),
    .ready   (keyReady)
  );

  rkb_datapath #(
    .KEY_BITS  (KEY_BITS),
    .BLK_BITS  (BLK_BITS),
    .WORD_BITS (WORD_BITS),
    .IDX_BITS  (IDX_BITS),
    .NSLOT     (SLOTS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .keyIn    (keyIn),
    .keyIdx   (keyIdx),
    .subIn    (subIn),
    .subOut   (subOut),
    .roundKey (roundKey)
  );
endmodule

// File: tb/round_key_bank_tb_top.sv
module round_key_bank_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [255:0] keyIn = '0;
  logic         wideKey = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   keyIdx = '0;
  logic [127:0] roundKey;
  logic         keyReady;
  logic [31:0]  subOut;
  logic [31:0]  subIn;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  round_key_bank dut_i (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .wideKey(wideKey), .start(start),
    .keyIdx(keyIdx), .roundKey(roundKey), .keyReady(keyReady),
    .subOut(subOut), .subIn(subIn)
  );

  // Substitution model, table computed at time zero.
  logic [7:0] sbTab [256];

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] rl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  always_comb begin
    for (int b = 0; b < 4; b++) subIn[b*8 +: 8] = sbTab[subOut[b*8 +: 8]];
  end

  function automatic logic [31:0] subw(input logic [31:0] w);
    for (int b = 0; b < 4; b++) subw[b*8 +: 8] = sbTab[w[b*8 +: 8]];
  endfunction

  // Reference schedule from the textbook word recurrence.
  logic [127:0] refKeys [15];

  task automatic buildRef(input logic [255:0] k, input bit wide);
    logic [31:0] w [60];
    int nk = wide ? 8 : 4;
    int nr = wide ? 14 : 10;
    logic [7:0] rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < nk; i++) w[i] = k[255 - 32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = w[i-1];
      if (i % nk == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end else if (nk > 4 && i % nk == 4) begin
        t = subw(t);
      end
      w[i] = w[i-nk] ^ t;
    end
    for (int r = 0; r < 15; r++)
      refKeys[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : 128'h0;
  endtask

  // Scoreboard
  typedef struct {
    string        req;
    logic [3:0]   idx;
    logic [127:0] exp;
  } item_t;
  item_t sbq[$];

  always @(negedge clk) begin : monitor
    item_t it;
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      nChk++;
      if (roundKey !== it.exp) begin
        nFail++;
        $display("FAIL %s idx %0d: got %h expected %h", it.req, it.idx, roundKey, it.exp);
      end
    end
  end

  task automatic pushRead(input string req, input int idx, input logic [127:0] exp);
    @(posedge clk);
    #1 keyIdx = idx[3:0];
    sbq.push_back('{req, idx[3:0], exp});
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Start a run; returns number of falling edges with ready low.
  task automatic runKey(input logic [255:0] k, input bit wide, input bit holdTwo,
                        input bit midPulse, output int lowCnt);
    @(posedge clk);
    #1 keyIn = k; wideKey = wide; start = 1'b1;
    @(posedge clk);
    #1 if (!holdTwo) start = 1'b0;
    lowCnt = 0;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (keyReady) break;
      lowCnt++;
      if (holdTwo && lowCnt == 1) start = 1'b0;
      if (midPulse && lowCnt == 5) start = 1'b1;
      if (midPulse && lowCnt == 6) start = 1'b0;
    end
  endtask

  localparam logic [255:0] NIST_HI = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};

  initial begin : watchdog
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin : main
    int lowCnt;
    // Build the substitution table: inverse then affine map.
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int y = 1; y < 256; y++) if (gm(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
      sbTab[x] = inv ^ rl8(inv,1) ^ rl8(inv,2) ^ rl8(inv,3) ^ rl8(inv,4) ^ 8'h63;
    end

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ready", {127'h0, keyReady}, 128'h1);
    pushRead("R1", 0, 128'h0);
    pushRead("R1", 7, 128'h0);
    drain();

    // R5: all-zero narrow key, literal round 1 and full schedule; R2 timing
    runKey(256'h0, 1'b0, 1'b0, 1'b0, lowCnt);
    chk("R2 narrow ready-low cycles", 128'(lowCnt), 128'd11);
    buildRef(256'h0, 1'b0);
    pushRead("R5 literal", 1, {4{32'h62636363}});
    for (int r = 0; r <= 10; r++) pushRead("R5", r, refKeys[r]);
    drain();

    // R3: narrow key with junk low half; R9 start held two cycles
    runKey(NIST_HI | 256'hdeadbeef_0badf00d_12345678_9abcdef0, 1'b0, 1'b1, 1'b0, lowCnt);
    chk("R9 held start ready-low cycles", 128'(lowCnt), 128'd11);
    buildRef(NIST_HI, 1'b0);
    pushRead("R5 literal", 1, 128'ha0fafe1788542cb123a339392a6c7605);
    pushRead("R4 key0", 0, NIST_HI[255:128]);
    for (int r = 0; r <= 10; r++) pushRead("R3", r, refKeys[r]);
    drain();

    // R6: wide key, R4 key1 is low half; R9 mid-run pulse
    runKey(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
           1'b1, 1'b0, 1'b1, lowCnt);
    chk("R2 wide ready-low cycles", 128'(lowCnt), 128'd15);
    buildRef(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 1'b1);
    pushRead("R4 key1", 1, 128'h101112131415161718191a1b1c1d1e1f);
    for (int r = 0; r <= 14; r++) pushRead("R6", r, refKeys[r]);
    // R8: index 15 reads zero
    pushRead("R8", 15, 128'h0);
    drain();

    // R6 and R10: second wide key exercising rotate/plain substitution words
    runKey({8{32'hc3a5_5a3c}}, 1'b1, 1'b0, 1'b0, lowCnt);
    buildRef({8{32'hc3a5_5a3c}}, 1'b1);
    for (int r = 14; r >= 0; r--) pushRead("R10", r, refKeys[r]);
    drain();

    // R7: index sweeps back and forth each cycle with no gap
    for (int r = 0; r < 6; r++) begin
      pushRead("R7", (r % 2) ? 13 : 2, refKeys[(r % 2) ? 13 : 2]);
    end
    drain();

    // R3: narrow run after wide overwrites slots 0..10
    runKey(256'hffffffffffffffffffffffffffffffff_5555aaaa5555aaaa5555aaaa5555aaaa,
           1'b0, 1'b0, 1'b0, lowCnt);
    buildRef({128'hffffffffffffffffffffffffffffffff, 128'h0}, 1'b0);
    for (int r = 0; r <= 10; r++) pushRead("R3", r, refKeys[r]);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule